// File: doc/BRIEF.md
# Packed Six-Slot Nibble Priority Queue

This block keeps a small priority queue inside a single 32-bit state register. The low 24 bits hold six 4-bit items, one per slot. Six bits above them record which slots hold a live item. A pop command takes the item from the occupied slot with the lowest index. It then marks that slot free and fills its nibble with all ones. A push command stores a new nibble in the free slot with the lowest index.

A parallel load replaces the whole word in one step. Push and pop may arrive in the same cycle. In that case the pop acts first and the push then lands in the word the pop left behind. The popped nibble and its valid strobe come from registers, so they appear in the cycle that follows the request edge. The state word, empty flag and full flag are visible at all times.

Top module: `nibble_pq`

## Requirements
- R1: After reset the state word reads 0x00FFFFFF: all item nibbles are 0xF and every occupancy bit is 0. empty is 1, full is 0, pop_valid is 0 and pop_item is 0xF.
- R2: Slot k (k = 0..5) keeps its item in state bits 4k+3..4k. State bit 24+k set means slot k holds a valid item.
- R3: A pop on a non-empty queue picks the lowest-indexed slot whose occupancy bit is set. After the request edge, pop_item shows that slot's nibble and pop_valid is 1, both in the same cycle.
- R4: After a pop, the chosen slot's nibble reads 0xF and its occupancy bit reads 0. Every other bit of the state word is unchanged.
- R5: A pop while all six occupancy bits are 0 leaves the state word unchanged. In the following cycle pop_valid is 0 and pop_item is 0xF.
- R6: A push writes push_item into the lowest-indexed free slot and sets that slot's occupancy bit.
- R7: A push while all six occupancy bits are set leaves the state word unchanged.
- R8: When push and pop arrive in the same cycle, the pop is applied to the state held before the edge. The push then goes into the lowest free slot of that updated state. This holds when the queue was full: the slot just popped is the one refilled.
- R9: load_en replaces the state word with load_word, with bits 31..30 forced to 0. It takes priority over push and pop in the same cycle, and pop_valid is 0 in the following cycle.
- R10: empty is 1 exactly when state bits 29..24 are all 0. full is 1 exactly when they are all 1.
- R11: State bits 31..30 are always 0.
- R12: In a cycle that follows an edge with no pop request, pop_valid is 0 and pop_item is 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pop_req | input | 1 | Pop the lowest occupied slot at this edge |
| push_req | input | 1 | Push push_item into the lowest free slot at this edge |
| push_item | input | 4 | Nibble to push |
| load_en | input | 1 | Replace the state word with load_word |
| load_word | input | 32 | Word for the parallel load |
| pop_item | output | 4 | Nibble returned by the last pop, 0xF otherwise |
| pop_valid | output | 1 | The last edge popped a real item |
| empty | output | 1 | No slot occupied |
| full | output | 1 | All six slots occupied |
| state_word | output | 32 | Raw packed state |

## Verification
The bench loads sparse occupancy patterns, so a design that scans from the top slot, or that takes the first slot instead of the first occupied one, returns the wrong nibble. A combined push and pop on a full queue must refill the slot that was just freed. A design that evaluates the push first would drop that push as a push to a full queue. Pops on an empty queue and pushes to a full queue must leave the word untouched, and a loaded word with its top two bits set must come back with them cleared. A load that arrives together with push and pop must win, so a design that lets either command through alters the loaded word.

// File: rtl/nibble_pq_pkg.sv
package nibble_pq_pkg;
  localparam int unsigned PQ_SLOTS  = 6;
  localparam int unsigned PQ_ITEM_W = 4;
  localparam int unsigned PQ_WORD_W = 32;
endpackage

// File: rtl/pq_lowest_pick.sv
module pq_lowest_pick #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] onehot,
  output logic         any
);
  logic seen;
  always_comb begin
    seen   = 1'b0;
    onehot = '0;
    for (int i = 0; i < int'(N); i++) begin
      onehot[i] = req[i] & ~seen;
      seen      = seen | req[i];
    end
    any = seen;
  end
endmodule

// File: rtl/pq_slot_write.sv
module pq_slot_write #(
  parameter int unsigned SLOTS  = 6,
  parameter int unsigned ITEM_W = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [SLOTS-1:0]  sel,
  input  logic [ITEM_W-1:0] new_item,
  input  logic              new_flag,
  output logic [ITEM_W-1:0] old_item,
  output logic [WORD_W-1:0] word_out
);
  localparam int unsigned FLAG_LSB = SLOTS * ITEM_W;

  logic [SLOTS-1:0][ITEM_W-1:0] picked;

  for (genvar k = 0; k < int'(SLOTS); k++) begin : g_slot
    assign picked[k] = sel[k] ? word_in[k*ITEM_W +: ITEM_W] : '0;
    assign word_out[k*ITEM_W +: ITEM_W] =
      sel[k] ? new_item : word_in[k*ITEM_W +: ITEM_W];
    assign word_out[FLAG_LSB + k] = sel[k] ? new_flag : word_in[FLAG_LSB + k];
  end

  if (WORD_W > FLAG_LSB + SLOTS) begin : g_upper
    assign word_out[WORD_W-1:FLAG_LSB+SLOTS] = word_in[WORD_W-1:FLAG_LSB+SLOTS];
  end

  always_comb begin
    old_item = '0;
    for (int k = 0; k < int'(SLOTS); k++) old_item = old_item | picked[k];
  end
endmodule

// File: rtl/nibble_pq.sv
module nibble_pq
  import nibble_pq_pkg::*;
#(
  parameter int unsigned SLOTS  = PQ_SLOTS,
  parameter int unsigned ITEM_W = PQ_ITEM_W,
  parameter int unsigned WORD_W = PQ_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_req,
  input  logic              push_req,
  input  logic [ITEM_W-1:0] push_item,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  output logic [ITEM_W-1:0] pop_item,
  output logic              pop_valid,
  output logic              empty,
  output logic              full,
  output logic [WORD_W-1:0] state_word
);
  localparam int unsigned FLAG_LSB = SLOTS * ITEM_W;
  localparam int unsigned USED_W   = FLAG_LSB + SLOTS;
  localparam logic [WORD_W-1:0] KEEP_MASK  = WORD_W'((64'd1 << USED_W) - 64'd1);
  localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'((64'd1 << FLAG_LSB) - 64'd1);
  localparam logic [ITEM_W-1:0] FREE_ITEM  = '1;

  logic [WORD_W-1:0] state_q, state_d;
  logic              state_en;
  logic [ITEM_W-1:0] pop_item_q, pop_item_d;
  logic              pop_valid_q, pop_valid_d;

  logic [SLOTS-1:0]  occ_now, occ_mid;
  logic [SLOTS-1:0]  pop_hot, push_hot, pop_sel, push_sel;
  logic              pop_any, push_room;
  logic [WORD_W-1:0] word_popped, word_pushed;
  logic [ITEM_W-1:0] pop_nib, push_unused;
  logic              do_pop, do_push;

  assign occ_now = state_q[FLAG_LSB +: SLOTS];

  // Pop stage acts on the state held before the edge.
  pq_lowest_pick #(.N(SLOTS)) u_pop_pick (
    .req(occ_now), .onehot(pop_hot), .any(pop_any)
  );

  assign do_pop  = pop_req & pop_any;
  assign pop_sel = pop_req ? pop_hot : '0;

  pq_slot_write #(.SLOTS(SLOTS), .ITEM_W(ITEM_W), .WORD_W(WORD_W)) u_pop_write (
    .word_in(state_q), .sel(pop_sel), .new_item(FREE_ITEM), .new_flag(1'b0),
    .old_item(pop_nib), .word_out(word_popped)
  );

  // Push stage acts on the word the pop stage produced.
  assign occ_mid = word_popped[FLAG_LSB +: SLOTS];

  pq_lowest_pick #(.N(SLOTS)) u_push_pick (
    .req(~occ_mid), .onehot(push_hot), .any(push_room)
  );

  assign do_push  = push_req & push_room;
  assign push_sel = push_req ? push_hot : '0;

  pq_slot_write #(.SLOTS(SLOTS), .ITEM_W(ITEM_W), .WORD_W(WORD_W)) u_push_write (
    .word_in(word_popped), .sel(push_sel), .new_item(push_item), .new_flag(1'b1),
    .old_item(push_unused), .word_out(word_pushed)
  );

  always_comb begin
    state_en    = load_en | do_pop | do_push;
    state_d     = load_en ? (load_word & KEEP_MASK) : (word_pushed & KEEP_MASK);
    pop_valid_d = do_pop & ~load_en;
    pop_item_d  = pop_valid_d ? pop_nib : FREE_ITEM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_WORD;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_item_q  <= FREE_ITEM;
      pop_valid_q <= 1'b0;
    end else begin
      pop_item_q  <= pop_item_d;
      pop_valid_q <= pop_valid_d;
    end
  end

  assign state_word = state_q;
  assign pop_item   = pop_item_q;
  assign pop_valid  = pop_valid_q;
  assign empty      = ~|occ_now;
  assign full       = &occ_now;
endmodule

// File: rtl/nibble_pq_chk.sv
module nibble_pq_chk #(
  parameter int unsigned SLOTS  = 6,
  parameter int unsigned ITEM_W = 4,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pop_req,
  input logic              push_req,
  input logic              load_en,
  input logic [ITEM_W-1:0] pop_item,
  input logic              pop_valid,
  input logic              empty,
  input logic              full,
  input logic [WORD_W-1:0] state_word
);
  localparam int unsigned FLAG_LSB = SLOTS * ITEM_W;
  logic [SLOTS-1:0] occ;
  assign occ = state_word[FLAG_LSB +: SLOTS];

  AST_POP_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !empty && !push_req && !load_en |=>
      pop_valid && ($countones(occ) == $countones($past(occ)) - 1)); // R4

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && empty && !push_req && !load_en |=>
      !pop_valid && (pop_item == '1) && $stable(state_word)); // R5

  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && full && !pop_req && !load_en |=> $stable(state_word)); // R7

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_req |=> !pop_valid && (pop_item == '1)); // R12

  AST_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !pop_valid); // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R10

  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_word[WORD_W-1:FLAG_LSB+SLOTS] == '0); // R11
endmodule

bind nibble_pq nibble_pq_chk #(.SLOTS(SLOTS), .ITEM_W(ITEM_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .push_req(push_req),
  .load_en(load_en), .pop_item(pop_item), .pop_valid(pop_valid),
  .empty(empty), .full(full), .state_word(state_word)
);

// File: tb/nibble_pq_tb.sv
module nibble_pq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pop_req = 1'b0, push_req = 1'b0, load_en = 1'b0;
  logic [3:0]  push_item = '0;
  logic [31:0] load_word = '0;
  logic [3:0]  pop_item;
  logic        pop_valid, empty, full;
  logic [31:0] state_word;

  int total = 0, bad = 0;
  logic [31:0] exp_word;

  always #2.5 clk = ~clk;

  nibble_pq u_dut (
    .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .push_req(push_req),
    .push_item(push_item), .load_en(load_en), .load_word(load_word),
    .pop_item(pop_item), .pop_valid(pop_valid), .empty(empty), .full(full),
    .state_word(state_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Independent reference: slot k nibble at [4k+3:4k], flag at bit 24+k.
  task automatic ref_pop(inout logic [31:0] w, output logic [3:0] it, output logic v);
    it = 4'hF; v = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (!v && w[24+k]) begin
        v = 1'b1; it = w[4*k +: 4];
        w[4*k +: 4] = 4'hF; w[24+k] = 1'b0;
      end
    end
  endtask

  task automatic ref_push(inout logic [31:0] w, input logic [3:0] it);
    logic done = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (!done && !w[24+k]) begin
        done = 1'b1; w[4*k +: 4] = it; w[24+k] = 1'b1;
      end
    end
  endtask

  // Apply one edge with the given commands, then check at the next negedge.
  task automatic step(input string req, input logic pp, input logic ps,
                      input logic [3:0] it, input logic ld, input logic [31:0] lw);
    logic [3:0] e_it; logic e_v;
    e_it = 4'hF; e_v = 1'b0;
    if (ld) exp_word = lw & 32'h3FFF_FFFF;
    else begin
      if (pp) ref_pop(exp_word, e_it, e_v);
      if (ps) ref_push(exp_word, it);
    end
    pop_req = pp; push_req = ps; push_item = it; load_en = ld; load_word = lw;
    @(posedge clk);
    @(negedge clk);
    pop_req = 0; push_req = 0; load_en = 0;
    chk({req, " state"}, state_word, exp_word);
    chk({req, " valid"}, {31'b0, pop_valid}, {31'b0, e_v});
    chk({req, " item"}, {28'b0, pop_item}, {28'b0, e_it});
    chk("R10 empty", {31'b0, empty}, {31'b0, exp_word[29:24] == 6'h00});
    chk("R10 full", {31'b0, full}, {31'b0, exp_word[29:24] == 6'h3F});
    chk("R11 top bits", {30'b0, state_word[31:30]}, 32'h0);
  endtask

  task automatic t_reset();
    exp_word = 32'h00FF_FFFF;
    chk("R1 state", state_word, 32'h00FF_FFFF);
    chk("R1 empty", {31'b0, empty}, 32'h1);
    chk("R1 full", {31'b0, full}, 32'h0);
    chk("R1 valid", {31'b0, pop_valid}, 32'h0);
    chk("R1 item", {28'b0, pop_item}, 32'hF);
  endtask

  task automatic t_fill();
    logic [3:0] items [6] = '{4'h3, 4'hA, 4'h5, 4'h0, 4'hC, 4'h7};
    for (int i = 0; i < 6; i++) step("R6 push", 0, 1, items[i], 0, 0);
    chk("R2 layout", state_word, 32'h3F7C_05A3);
    step("R7 push full", 0, 1, 4'h9, 0, 0);
    chk("R7 unchanged", state_word, 32'h3F7C_05A3);
  endtask

  task automatic t_drain();
    step("R3 pop", 1, 0, 0, 0, 0);
    chk("R3 first item", {28'b0, pop_item}, 32'h3);
    for (int i = 0; i < 5; i++) step("R4 pop", 1, 0, 0, 0, 0);
    chk("R4 drained", state_word, 32'h00FF_FFFF);
    step("R5 pop empty", 1, 0, 0, 0, 0);
    step("R12 idle", 0, 0, 0, 0, 0);
  endtask

  task automatic t_sparse();
    step("R9 load", 1, 1, 4'h2, 1, 32'hE89B_4D21);
    chk("R9 loaded", state_word, 32'h289B_4D21);
    step("R3 sparse pop", 1, 0, 0, 0, 0);
    chk("R3 slot3 item", {28'b0, pop_item}, 32'h4);
    chk("R4 slot3 freed", state_word, 32'h209B_FD21);
    step("R8 push+pop", 1, 1, 4'h6, 0, 0);
    chk("R8 result", state_word, 32'h01FB_FD26);
    chk("R8 item", {28'b0, pop_item}, 32'h9);
  endtask

  task automatic t_full_both();
    step("R9 load full", 0, 0, 0, 1, 32'h3F12_3456);
    step("R8 full push+pop", 1, 1, 4'hB, 0, 0);
    chk("R8 refill slot0", state_word, 32'h3F12_345B);
    chk("R8 full item", {28'b0, pop_item}, 32'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_drain();
    t_sparse();
    t_full_both();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule